// File: doc/BRIEF.md
# Word Memory with Null Flag

This block is a word-organised memory in which every word carries one extra tag bit. When the tag is set, the word counts as empty. A single request port takes read and write operations one at a time. A write either stores a data word or marks the word empty. Marking a word empty sets only its tag. The data bits stay frozen underneath it, so a later data write that repeats the frozen value costs no array update.

Completion timing follows the work the memory actually does. A write whose new value already matches the stored bits finishes in one cycle, and so does a write that marks a word empty. A write that must flip at least one bit takes a second cycle to update the array. A read of an empty word reports the empty result after one cycle. A read of a filled word fetches the data and takes two cycles.

The controller has five named states:
- Idle: `ready` is high and a request is accepted.
- Write-compare: the stored word is compared with the new value, and the tag is set or cleared.
- Write-commit: the changed word is written into the array.
- Read-tag: the tag of the addressed word is inspected.
- Read-fetch: the data of a filled word is returned.

The transitions are:
- Idle goes to Write-compare on an accepted write and to Read-tag on an accepted read.
- Write-compare returns to Idle for an empty-mark or an unchanged word, and goes to Write-commit when any bit differs.
- Write-commit goes to Idle.
- Read-tag returns to Idle for an empty word and goes to Read-fetch for a filled word.
- Read-fetch goes to Idle.

Top module: `nullmem_core`

## Requirements
- R1: After reset every word is empty, `ready` is 1, and `wr_done` and `rd_valid` are 0. A read of any word before it is written returns an empty result.
- R2: A write with `req_null`=1 sets the word's tag and ignores `req_wdata`. The data bits remain as they were, which a later matching data write shows by completing in one cycle.
- R3: A write with `req_null`=0 clears the word's tag and stores `req_wdata`. A later read returns that value with `rd_null`=0.
- R4: Latency is counted from the accepting clock edge to the edge after which `wr_done` is high. Write latency is 1 when the stored data equals `req_wdata` or when the write sets the tag. It is 2 when any data bit differs.
- R5: A data write to an empty word compares against the data frozen under the tag. An equal value completes in 1 cycle and a differing value completes in 2.
- R6: A read of an empty word gives `rd_valid`=1 and `rd_null`=1 with `rd_data` all zeros, 1 cycle after acceptance.
- R7: A read of a filled word gives `rd_valid`=1 and `rd_null`=0 with the stored data, 2 cycles after acceptance.
- R8: A request is accepted only on a clock edge where `req_valid` and `ready` are both 1. `ready` is low from acceptance until the result cycle, and requests offered while busy have no effect.
- R9: `wr_done` and `rd_valid` are single-cycle pulses, one per accepted operation, and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_null | input | 1 | On a write: 1 marks the word empty, 0 stores data |
| req_addr | input | AW | Word address, AW = clog2(DEPTH) |
| req_wdata | input | WIDTH | Write data |
| ready | output | 1 | Idle and able to accept a request |
| wr_done | output | 1 | Write finished (one-cycle pulse) |
| rd_valid | output | 1 | Read result present (one-cycle pulse) |
| rd_null | output | 1 | Read result is the empty indication |
| rd_data | output | WIDTH | Read data, zero for an empty result |

## Verification
The bench builds the memory with 16 words of 8 bits. This lets it sweep every address, including the top one, both before and after filling. It can also flip all bits of a word at once, since a full-width inversion is cheap to form. The small width keeps the single-bit, all-bit and no-bit change patterns easy to enumerate. The bench replays the frozen-data cases (empty-mark, matching refill, differing refill) on separate words, so that each completion time is observed in isolation.

// File: rtl/nullmem_pkg.sv
package nullmem_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WR_CMP   = 3'd1,
        ST_WR_FIX   = 3'd2,
        ST_RD_TAG   = 3'd3,
        ST_RD_FETCH = 3'd4
    } nm_state_e;

endpackage

// File: rtl/nullmem_store.sv
module nullmem_store #(
    parameter int DEPTH = 1024,
    parameter int WIDTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             data_we,
    input  logic             flag_set,
    input  logic             flag_clr,
    output logic [WIDTH-1:0] cur_word,
    output logic             cur_null
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [DEPTH-1:0] empty_tag;

    // data array: no reset, contents defined only once written
    always_ff @(posedge clk) begin
        if (data_we) begin
            mem[addr] <= wdata;
        end
    end

    // one tag flop per word, all set on reset
    for (genvar w = 0; w < DEPTH; w++) begin : g_tag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                empty_tag[w] <= 1'b1;
            end else if (int'(addr) == w) begin
                if (flag_set) begin
                    empty_tag[w] <= 1'b1;
                end else if (flag_clr) begin
                    empty_tag[w] <= 1'b0;
                end
            end
        end
    end

    assign cur_word = mem[addr];
    assign cur_null = empty_tag[addr];

endmodule

// File: rtl/nullmem_fsm.sv
module nullmem_fsm
    import nullmem_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int AW    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_null,
    input  logic [AW-1:0]    req_addr,
    input  logic [WIDTH-1:0] req_wdata,
    input  logic [WIDTH-1:0] cur_word,
    input  logic             cur_null,
    output logic             ready,
    output logic [AW-1:0]    op_addr,
    output logic [WIDTH-1:0] op_wdata,
    output logic             data_we,
    output logic             flag_set,
    output logic             flag_clr,
    output logic             wr_done,
    output logic             rd_valid,
    output logic             rd_null,
    output logic [WIDTH-1:0] rd_data
);

    nm_state_e state, state_nx;
    logic      op_null;
    logic      differs;
    logic      accept;

    assign accept  = (state == ST_IDLE) && req_valid;
    assign differs = (cur_word != op_wdata);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    state_nx = req_write ? ST_WR_CMP : ST_RD_TAG;
                end
            end
            ST_WR_CMP: begin
                state_nx = (op_null || !differs) ? ST_IDLE : ST_WR_FIX;
            end
            ST_WR_FIX: begin
                state_nx = ST_IDLE;
            end
            ST_RD_TAG: begin
                state_nx = cur_null ? ST_IDLE : ST_RD_FETCH;
            end
            ST_RD_FETCH: begin
                state_nx = ST_IDLE;
            end
            default: begin
                state_nx = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // array and tag controls
    assign ready    = (state == ST_IDLE);
    assign flag_set = (state == ST_WR_CMP) && op_null;
    assign flag_clr = (state == ST_WR_CMP) && !op_null;
    assign data_we  = (state == ST_WR_FIX);

    // registered outputs and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_addr  <= '0;
            op_wdata <= '0;
            op_null  <= 1'b0;
            wr_done  <= 1'b0;
            rd_valid <= 1'b0;
            rd_null  <= 1'b0;
            rd_data  <= '0;
        end else begin
            if (accept) begin
                op_addr  <= req_addr;
                op_wdata <= req_wdata;
                op_null  <= req_null;
            end
            wr_done  <= ((state == ST_WR_CMP) && (op_null || !differs))
                        || (state == ST_WR_FIX);
            rd_valid <= ((state == ST_RD_TAG) && cur_null)
                        || (state == ST_RD_FETCH);
            rd_null  <= (state == ST_RD_TAG) && cur_null;
            rd_data  <= (state == ST_RD_FETCH) ? cur_word : '0;
        end
    end

endmodule

// File: rtl/nullmem_core.sv
module nullmem_core #(
    parameter int DEPTH = 1024,
    parameter int WIDTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_null,
    input  logic [AW-1:0]    req_addr,
    input  logic [WIDTH-1:0] req_wdata,
    output logic             ready,
    output logic             wr_done,
    output logic             rd_valid,
    output logic             rd_null,
    output logic [WIDTH-1:0] rd_data
);

    logic [AW-1:0]    op_addr;
    logic [WIDTH-1:0] op_wdata;
    logic [WIDTH-1:0] cur_word;
    logic             cur_null;
    logic             data_we;
    logic             flag_set;
    logic             flag_clr;

    nullmem_fsm #(
        .WIDTH (WIDTH),
        .AW    (AW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_null  (req_null),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .cur_word  (cur_word),
        .cur_null  (cur_null),
        .ready     (ready),
        .op_addr   (op_addr),
        .op_wdata  (op_wdata),
        .data_we   (data_we),
        .flag_set  (flag_set),
        .flag_clr  (flag_clr),
        .wr_done   (wr_done),
        .rd_valid  (rd_valid),
        .rd_null   (rd_null),
        .rd_data   (rd_data)
    );

    nullmem_store #(
        .DEPTH (DEPTH),
        .WIDTH (WIDTH),
        .AW    (AW)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (op_addr),
        .wdata    (op_wdata),
        .data_we  (data_we),
        .flag_set (flag_set),
        .flag_clr (flag_clr),
        .cur_word (cur_word),
        .cur_null (cur_null)
    );

endmodule

// File: rtl/nullmem_sva.sv
module nullmem_sva #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             ready,
    input logic             wr_done,
    input logic             rd_valid,
    input logic             rd_null,
    input logic [WIDTH-1:0] rd_data
);

    assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ready) |=> !ready);

    assert_result_means_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done || rd_valid) |-> ready);

    assert_no_dual_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_done && rd_valid));

    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done || rd_valid) |=> !(wr_done || rd_valid));

    assert_empty_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_null |-> (rd_valid && (rd_data == '0)));

    assert_empty_fast_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_null) |-> ($past(ready, 2) && !$past(ready)));

    assert_fetch_slow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_null) |-> (!$past(ready) && !$past(ready, 2)));

endmodule

bind nullmem_core nullmem_sva #(.WIDTH(WIDTH)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .ready     (ready),
    .wr_done   (wr_done),
    .rd_valid  (rd_valid),
    .rd_null   (rd_null),
    .rd_data   (rd_data)
);

// File: tb/sim_nullmem_core.sv
module sim_nullmem_core;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int WIDTH      = 8;
    localparam int AW         = $clog2(DEPTH);

    typedef struct {
        bit               is_wr;
        bit               nul;
        logic [WIDTH-1:0] data;
        int               lat;
        bit               chk_lat;
        int               acc;
        string            tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_write = 1'b0;
    logic             req_null = 1'b0;
    logic [AW-1:0]    req_addr = '0;
    logic [WIDTH-1:0] req_wdata = '0;
    logic             ready;
    logic             wr_done;
    logic             rd_valid;
    logic             rd_null;
    logic [WIDTH-1:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    exp_t sb[$];

    logic [WIDTH-1:0] ref_data [DEPTH];
    bit               ref_null [DEPTH];
    bit               ref_known [DEPTH];

    nullmem_core #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_null  (req_null),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ready     (ready),
        .wr_done   (wr_done),
        .rd_valid  (rd_valid),
        .rd_null   (rd_null),
        .rd_data   (rd_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // driver: waits for ready, pushes the expected result, issues the request
    task automatic do_op(bit wr, bit nl, int a, logic [WIDTH-1:0] d, string tag);
        exp_t e;
        @(negedge clk);
        while (!ready) @(negedge clk);
        e.is_wr   = wr;
        e.tag     = tag;
        e.acc     = cyc + 1;
        e.chk_lat = 1'b1;
        e.nul     = 1'b0;
        e.data    = '0;
        if (wr) begin
            if (nl) begin
                e.lat = 1;
                ref_null[a] = 1'b1;
            end else begin
                e.chk_lat = ref_known[a];
                e.lat     = (ref_data[a] != d) ? 2 : 1;
                ref_data[a]  = d;
                ref_known[a] = 1'b1;
                ref_null[a]  = 1'b0;
            end
        end else begin
            e.nul  = ref_null[a];
            e.data = ref_null[a] ? '0 : ref_data[a];
            e.lat  = ref_null[a] ? 1 : 2;
        end
        sb.push_back(e);
        req_write = wr;
        req_null  = nl;
        req_addr  = AW'(a);
        req_wdata = d;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // offer a conflicting write while busy; it must be dropped (R8)
    task automatic poke_busy(int a, logic [WIDTH-1:0] d);
        req_write = 1'b1;
        req_null  = 1'b0;
        req_addr  = AW'(a);
        req_wdata = d;
        req_valid = 1'b1;
        while (1) begin
            @(negedge clk);
            if (ready) break;
        end
        req_valid = 1'b0;
    endtask

    // monitor: compares each result pulse with the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_done && rd_valid) begin
                check(1'b0, "R9", "both result pulses high", 1, 0);
            end
            if (wr_done || rd_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R9", "unexpected result pulse", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(wr_done == e.is_wr, e.tag, "result kind", int'(wr_done), int'(e.is_wr));
                    if (!e.is_wr) begin
                        check(rd_null == e.nul, e.tag, "rd_null", int'(rd_null), int'(e.nul));
                        check(rd_data == e.data, e.tag, "rd_data", int'(rd_data), int'(e.data));
                    end
                    if (e.chk_lat) begin
                        check((cyc - e.acc) == e.lat, e.tag, "latency", cyc - e.acc, e.lat);
                    end
                end
            end
        end
    end

    task automatic run_all();
        for (int i = 0; i < DEPTH; i++) begin
            ref_null[i]  = 1'b1;
            ref_known[i] = 1'b0;
            ref_data[i]  = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        check(ready == 1'b1, "R1", "ready after reset", int'(ready), 1);
        check(wr_done == 1'b0 && rd_valid == 1'b0, "R1", "no result after reset",
              int'(wr_done | rd_valid), 0);
        // R1, R6: every word empty before any write
        for (int i = 0; i < DEPTH; i++) do_op(1'b0, 1'b0, i, '0, "R1");
        // R3: fill every word (first-write latency not predictable)
        for (int i = 0; i < DEPTH; i++) do_op(1'b1, 1'b0, i, WIDTH'(i * 37 + 90), "R3");
        // R7: data reads take two cycles
        for (int i = 0; i < DEPTH; i++) do_op(1'b0, 1'b0, i, '0, "R7");
        // R4: unchanged, all-bit and single-bit changes
        do_op(1'b1, 1'b0, 3, ref_data[3], "R4");
        do_op(1'b1, 1'b0, 4, ~ref_data[4], "R4");
        do_op(1'b1, 1'b0, 5, ref_data[5] ^ WIDTH'(1), "R4");
        do_op(1'b0, 1'b0, 4, '0, "R4");
        // R2, R6: empty-mark then read, then mark again
        do_op(1'b1, 1'b1, 6, 8'hA5, "R2");
        do_op(1'b0, 1'b0, 6, '0, "R6");
        do_op(1'b1, 1'b1, 6, 8'h3C, "R2");
        // R5: matching refill is fast, read shows data again
        do_op(1'b1, 1'b0, 6, ref_data[6], "R5");
        do_op(1'b0, 1'b0, 6, '0, "R3");
        // R5: differing refill takes two cycles
        do_op(1'b1, 1'b1, 7, '0, "R2");
        do_op(1'b1, 1'b0, 7, ~ref_data[7], "R5");
        do_op(1'b0, 1'b0, 7, '0, "R5");
        // R2: garbage data on an empty-mark does not reach the array
        do_op(1'b1, 1'b1, 8, ~ref_data[8], "R2");
        do_op(1'b0, 1'b0, 8, '0, "R2");
        do_op(1'b1, 1'b0, 8, ref_data[8], "R2");
        // R8: request held while busy is dropped
        do_op(1'b1, 1'b0, 9, ~ref_data[9], "R8");
        poke_busy(9, 8'h00);
        do_op(1'b0, 1'b0, 9, '0, "R8");
        // top address: empty-mark and refill
        do_op(1'b1, 1'b1, DEPTH - 1, '0, "R2");
        do_op(1'b0, 1'b0, DEPTH - 1, '0, "R6");
        do_op(1'b1, 1'b0, DEPTH - 1, ref_data[DEPTH - 1], "R5");
        do_op(1'b0, 1'b0, DEPTH - 1, '0, "R7");
        while (sb.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        check(ready == 1'b1, "R9", "idle at end", int'(ready), 1);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (20000) @(posedge clk);
                check(1'b0, "R8", "watchdog expired", 0, 1);
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule